// File: doc/BRIEF.md
# Lock Contention Spin/Wait Classifier

This block watches the instructions retired by one processor and measures how long the processor contends for a lock before it gets it. An atomic read-modify-write that writes back the value already in memory leaves the lock unchanged, so it counts as a failed acquisition. The first such failure on an address opens a contention episode. The episode closes when an atomic operation on the same address changes the memory value, which is a successful acquisition.

The hardware cannot see thread switches. Episode length is therefore counted in retired instructions and compared with a fixed cutoff. An episode at or below the cutoff is short spinning. A longer one is treated as the thread having waited, for example while descheduled. Each closed episode produces a one-cycle report carrying its length and class.

Saturating counters keep running totals:
- spin episodes,
- wait episodes,
- instructions spent in spin episodes,
- uncontended acquisitions.

Wait episodes are left out of the instruction total, so a few very long waits cannot dominate the wasted-instruction figure. Only one episode is tracked at a time.

Top module: `contend_classifier`

## Requirements
- R1: After synchronous reset, `ep_done` is 0 and all four counters read 0.
- R2: A retired atomic op with `ret_old == ret_new` is a failed attempt. One with `ret_old != ret_new` is a successful acquisition. A successful acquisition with no open episode on its address adds 1 to `uncont_acqs` and raises no `ep_done`. A non-atomic instruction is never an attempt.
- R3: The episode length is the number of instructions retired after the failed attempt that opened the episode, up to and including the acquiring instruction. `ep_done` is high for exactly the one cycle after the acquiring instruction retires, with `ep_len` holding that length.
- R4: `ep_wait` is 1 when `ep_len > WAIT_LIMIT` and 0 when `ep_len <= WAIT_LIMIT`.
- R5: Each reported episode adds 1 to `spin_eps` if it is spinning, or to `wait_eps` if it is waiting. The counters update in the same cycle that `ep_done` rises.
- R6: `spin_instrs` grows by `ep_len` for spinning episodes and does not change for waiting ones.
- R7: A failed attempt on a different address while an episode is open restarts the episode on the new address, with its count cleared. A later acquisition of the old address is uncontended.
- R8: A further failed attempt on the open episode's own address does not restart the episode; it counts as one retired instruction.
- R9: Cycles with `ret_valid` low add nothing to the episode length. Non-atomic retired instructions add one each.
- R10: The episode length saturates at 2^TIMER_W-1 instead of wrapping.
- R11: All four counters saturate at 2^CNT_W-1.
- R12: A successful acquisition of another address while an episode is open counts as uncontended. The episode stays open, and the acquisition adds one to its length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ret_valid | input | 1 | One instruction retires this cycle |
| ret_atomic | input | 1 | The retiring instruction is an atomic read-modify-write |
| ret_addr | input | ADDR_W | Lock address of the atomic op |
| ret_old | input | DATA_W | Memory value before the atomic op |
| ret_new | input | DATA_W | Value the atomic op writes |
| ep_done | output | 1 | One-cycle pulse: an episode has closed |
| ep_len | output | TIMER_W | Length of the closed episode in instructions |
| ep_wait | output | 1 | 1 = waiting episode, 0 = spinning episode |
| spin_eps | output | CNT_W | Count of spinning episodes |
| wait_eps | output | CNT_W | Count of waiting episodes |
| spin_instrs | output | CNT_W | Instructions summed over spinning episodes |
| uncont_acqs | output | CNT_W | Count of uncontended acquisitions |

## Verification
The bench builds the block with these parameters:
- `WAIT_LIMIT` = 16, which puts lengths 16 and 17 on either side of the cutoff within a few cycles.
- `TIMER_W` = 6, so the episode length pins at 63 after about seventy instructions.
- `CNT_W` = 8, so a few hundred short episodes drive the episode count and the spin instruction total into saturation.
- 8-bit addresses and data, which are enough to tell locks apart.

// File: rtl/ccls_pkg.sv
package ccls_pkg;

    // Kind of a retired instruction as seen by the classifier
    typedef enum logic [1:0] {
        EV_NONE  = 2'd0,   // nothing retired
        EV_PLAIN = 2'd1,   // ordinary instruction retired
        EV_FAIL  = 2'd2,   // atomic op left the lock value unchanged
        EV_GRAB  = 2'd3    // atomic op changed the lock value
    } ev_kind_e;

    typedef enum logic {
        CLS_SPIN = 1'b0,
        CLS_WAIT = 1'b1
    } ep_class_e;

    // Counter bank slots
    localparam int NUM_CNT     = 4;
    localparam int CI_SPIN_EP  = 0;
    localparam int CI_WAIT_EP  = 1;
    localparam int CI_SPIN_INS = 2;
    localparam int CI_UNCONT   = 3;

    function automatic ev_kind_e classify_retire(input logic valid,
                                                 input logic atomic,
                                                 input logic unchanged);
        if (!valid)
            return EV_NONE;
        else if (!atomic)
            return EV_PLAIN;
        else if (unchanged)
            return EV_FAIL;
        else
            return EV_GRAB;
    endfunction

endpackage

// File: rtl/ccls_event_decode.sv
module ccls_event_decode
    import ccls_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              valid,
    input  logic              atomic,
    input  logic [DATA_W-1:0] mem_old,
    input  logic [DATA_W-1:0] mem_new,
    output ev_kind_e          kind
);
    logic unchanged;

    always_comb begin
        unchanged = (mem_old == mem_new);
        kind      = classify_retire(valid, atomic, unchanged);
    end
endmodule

// File: rtl/ccls_episode.sv
module ccls_episode
    import ccls_pkg::*;
#(
    parameter int          ADDR_W     = 32,
    parameter int          TIMER_W    = 20,
    parameter int unsigned WAIT_LIMIT = 4096
) (
    input  logic               clk,
    input  logic               rst,
    input  ev_kind_e           kind,
    input  logic [ADDR_W-1:0]  addr,
    output logic               fin_valid,
    output logic [TIMER_W-1:0] fin_len,
    output ep_class_e          fin_cls,
    output logic               uncont_hit
);
    localparam logic [TIMER_W-1:0] TMAX = {TIMER_W{1'b1}};

    logic               open_q,  open_n;
    logic [ADDR_W-1:0]  addr_q,  addr_n;
    logic [TIMER_W-1:0] timer_q, timer_n;
    logic [TIMER_W-1:0] timer_inc;
    logic               same;

    always_comb begin
        same      = open_q && (addr == addr_q);
        timer_inc = (timer_q == TMAX) ? TMAX : timer_q + 1'b1;

        open_n     = open_q;
        addr_n     = addr_q;
        timer_n    = timer_q;
        fin_valid  = 1'b0;
        fin_len    = '0;
        uncont_hit = 1'b0;

        case (kind)
            EV_PLAIN: begin
                if (open_q) timer_n = timer_inc;
            end
            EV_FAIL: begin
                if (same) begin
                    timer_n = timer_inc;
                end else begin
                    open_n  = 1'b1;
                    addr_n  = addr;
                    timer_n = '0;
                end
            end
            EV_GRAB: begin
                if (same) begin
                    fin_valid = 1'b1;
                    fin_len   = timer_inc;
                    open_n    = 1'b0;
                    timer_n   = '0;
                end else begin
                    uncont_hit = 1'b1;
                    if (open_q) timer_n = timer_inc;
                end
            end
            default: ;
        endcase

        fin_cls = (32'(fin_len) > WAIT_LIMIT) ? CLS_WAIT : CLS_SPIN;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q  <= 1'b0;
            addr_q  <= '0;
            timer_q <= '0;
        end else begin
            open_q  <= open_n;
            addr_q  <= addr_n;
            timer_q <= timer_n;
        end
    end
endmodule

// File: rtl/ccls_sat_counter.sv
module ccls_sat_counter #(
    parameter int W     = 32,
    parameter int INC_W = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [INC_W-1:0] inc,
    output logic [W-1:0]     count
);
    localparam logic [W:0] MAXV = {1'b0, {W{1'b1}}};

    logic [W:0] sum;

    always_comb sum = {1'b0, count} + (W+1)'(inc);

    always_ff @(posedge clk) begin
        if (rst)
            count <= '0;
        else if (en)
            count <= (sum > MAXV) ? {W{1'b1}} : sum[W-1:0];
    end
endmodule

// File: rtl/contend_classifier.sv
module contend_classifier
    import ccls_pkg::*;
#(
    parameter int          ADDR_W     = 32,
    parameter int          DATA_W     = 32,
    parameter int          TIMER_W    = 20,
    parameter int          CNT_W      = 32,
    parameter int unsigned WAIT_LIMIT = 4096
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ret_valid,
    input  logic               ret_atomic,
    input  logic [ADDR_W-1:0]  ret_addr,
    input  logic [DATA_W-1:0]  ret_old,
    input  logic [DATA_W-1:0]  ret_new,
    output logic               ep_done,
    output logic [TIMER_W-1:0] ep_len,
    output logic               ep_wait,
    output logic [CNT_W-1:0]   spin_eps,
    output logic [CNT_W-1:0]   wait_eps,
    output logic [CNT_W-1:0]   spin_instrs,
    output logic [CNT_W-1:0]   uncont_acqs
);
    ev_kind_e           kind;
    logic               fin_valid;
    logic [TIMER_W-1:0] fin_len;
    ep_class_e          fin_cls;
    logic               uncont_hit;

    logic               cnt_en  [NUM_CNT];
    logic [TIMER_W-1:0] cnt_inc [NUM_CNT];
    logic [CNT_W-1:0]   cnt_val [NUM_CNT];

    ccls_event_decode #(.DATA_W(DATA_W)) u_decode (
        .valid   (ret_valid),
        .atomic  (ret_atomic),
        .mem_old (ret_old),
        .mem_new (ret_new),
        .kind    (kind)
    );

    ccls_episode #(
        .ADDR_W     (ADDR_W),
        .TIMER_W    (TIMER_W),
        .WAIT_LIMIT (WAIT_LIMIT)
    ) u_episode (
        .clk        (clk),
        .rst        (rst),
        .kind       (kind),
        .addr       (ret_addr),
        .fin_valid  (fin_valid),
        .fin_len    (fin_len),
        .fin_cls    (fin_cls),
        .uncont_hit (uncont_hit)
    );

    always_comb begin
        cnt_en[CI_SPIN_EP]   = fin_valid && (fin_cls == CLS_SPIN);
        cnt_inc[CI_SPIN_EP]  = TIMER_W'(1);
        cnt_en[CI_WAIT_EP]   = fin_valid && (fin_cls == CLS_WAIT);
        cnt_inc[CI_WAIT_EP]  = TIMER_W'(1);
        cnt_en[CI_SPIN_INS]  = fin_valid && (fin_cls == CLS_SPIN);
        cnt_inc[CI_SPIN_INS] = fin_len;
        cnt_en[CI_UNCONT]    = uncont_hit;
        cnt_inc[CI_UNCONT]   = TIMER_W'(1);
    end

    for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
        ccls_sat_counter #(.W(CNT_W), .INC_W(TIMER_W)) u_cnt (
            .clk   (clk),
            .rst   (rst),
            .en    (cnt_en[g]),
            .inc   (cnt_inc[g]),
            .count (cnt_val[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ep_done <= 1'b0;
            ep_len  <= '0;
            ep_wait <= 1'b0;
        end else begin
            ep_done <= fin_valid;
            ep_len  <= fin_len;
            ep_wait <= (fin_cls == CLS_WAIT);
        end
    end

    assign spin_eps    = cnt_val[CI_SPIN_EP];
    assign wait_eps    = cnt_val[CI_WAIT_EP];
    assign spin_instrs = cnt_val[CI_SPIN_INS];
    assign uncont_acqs = cnt_val[CI_UNCONT];
endmodule

// File: rtl/ccls_checker.sv
module ccls_checker #(
    parameter int          ADDR_W     = 32,
    parameter int          DATA_W     = 32,
    parameter int          TIMER_W    = 20,
    parameter int          CNT_W      = 32,
    parameter int unsigned WAIT_LIMIT = 4096
) (
    input logic               clk,
    input logic               rst,
    input logic               ret_valid,
    input logic               ret_atomic,
    input logic [ADDR_W-1:0]  ret_addr,
    input logic [DATA_W-1:0]  ret_old,
    input logic [DATA_W-1:0]  ret_new,
    input logic               ep_done,
    input logic [TIMER_W-1:0] ep_len,
    input logic               ep_wait,
    input logic [CNT_W-1:0]   spin_eps,
    input logic [CNT_W-1:0]   wait_eps,
    input logic [CNT_W-1:0]   spin_instrs,
    input logic [CNT_W-1:0]   uncont_acqs
);
    logic past_ok;

    always_ff @(posedge clk) begin
        if (rst) past_ok <= 1'b0;
        else     past_ok <= 1'b1;
    end

    // R3: a report follows only a retired atomic op that changed memory
    p_done_after_grab_r3: assert property (@(posedge clk) disable iff (rst)
        (past_ok && ep_done) |-> $past(ret_valid && ret_atomic && (ret_old != ret_new)));

    // R3: a reported episode holds at least the acquiring instruction
    p_len_nonzero_r3: assert property (@(posedge clk) disable iff (rst)
        ep_done |-> (ep_len != '0));

    // R4: class bit matches the cutoff
    p_class_cut_r4: assert property (@(posedge clk) disable iff (rst)
        ep_done |-> (ep_wait == (32'(ep_len) > WAIT_LIMIT)));

    // R6: waiting episodes leave the spin instruction total alone
    p_wait_no_instr_r6: assert property (@(posedge clk) disable iff (rst)
        (past_ok && ep_done && ep_wait) |-> (spin_instrs == $past(spin_instrs)));

    // R2: uncontended acquisitions never coincide with an episode report
    p_uncont_no_done_r2: assert property (@(posedge clk) disable iff (rst)
        (past_ok && (uncont_acqs != $past(uncont_acqs))) |-> !ep_done);

    // R9: an idle cycle cannot close an episode
    p_idle_no_done_r9: assert property (@(posedge clk) disable iff (rst)
        (past_ok && !$past(ret_valid)) |-> !ep_done);

    // R11: counters never move backward
    p_no_wrap_r11: assert property (@(posedge clk) disable iff (rst)
        past_ok |-> ((spin_instrs >= $past(spin_instrs)) && (spin_eps >= $past(spin_eps))
                     && (wait_eps >= $past(wait_eps)) && (uncont_acqs >= $past(uncont_acqs))));

    // R5: counters move only with a report of the matching class
    p_ep_cnt_class_r5: assert property (@(posedge clk) disable iff (rst)
        (past_ok && (wait_eps != $past(wait_eps))) |-> (ep_done && ep_wait));
endmodule

bind contend_classifier ccls_checker #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .TIMER_W    (TIMER_W),
    .CNT_W      (CNT_W),
    .WAIT_LIMIT (WAIT_LIMIT)
) u_ccls_checker (
    .clk         (clk),
    .rst         (rst),
    .ret_valid   (ret_valid),
    .ret_atomic  (ret_atomic),
    .ret_addr    (ret_addr),
    .ret_old     (ret_old),
    .ret_new     (ret_new),
    .ep_done     (ep_done),
    .ep_len      (ep_len),
    .ep_wait     (ep_wait),
    .spin_eps    (spin_eps),
    .wait_eps    (wait_eps),
    .spin_instrs (spin_instrs),
    .uncont_acqs (uncont_acqs)
);

// File: tb/tb_contend_classifier.sv
module tb_contend_classifier;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 8;
    localparam int DATA_W     = 8;
    localparam int TIMER_W    = 6;
    localparam int CNT_W      = 8;
    localparam int LIMIT      = 16;
    localparam int TMAXI      = (1 << TIMER_W) - 1;
    localparam int CMAXI      = (1 << CNT_W) - 1;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               ret_valid = 1'b0;
    logic               ret_atomic = 1'b0;
    logic [ADDR_W-1:0]  ret_addr = '0;
    logic [DATA_W-1:0]  ret_old = '0;
    logic [DATA_W-1:0]  ret_new = '0;
    logic               ep_done;
    logic [TIMER_W-1:0] ep_len;
    logic               ep_wait;
    logic [CNT_W-1:0]   spin_eps, wait_eps, spin_instrs, uncont_acqs;

    contend_classifier #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TIMER_W(TIMER_W),
        .CNT_W(CNT_W), .WAIT_LIMIT(LIMIT)
    ) dut (
        .clk(clk), .rst(rst), .ret_valid(ret_valid), .ret_atomic(ret_atomic),
        .ret_addr(ret_addr), .ret_old(ret_old), .ret_new(ret_new),
        .ep_done(ep_done), .ep_len(ep_len), .ep_wait(ep_wait),
        .spin_eps(spin_eps), .wait_eps(wait_eps),
        .spin_instrs(spin_instrs), .uncont_acqs(uncont_acqs)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int fails  = 0;
    bit done_flag = 0;

    typedef struct {
        int len;
        bit wt;
        string tag;
    } exp_item_t;
    exp_item_t exp_q[$];

    // Reference model state
    bit m_open = 0;
    int m_addr = 0;
    int m_t    = 0;
    int m_spin = 0, m_wait = 0, m_sins = 0, m_unc = 0;

    function automatic int sat_add(int a, int b);
        return (a + b > CMAXI) ? CMAXI : a + b;
    endfunction

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Driver: one retired instruction (or idle) per call
    task automatic retire(bit valid, bit atomic, int addr, int old_v, int new_v, string tag);
        @(negedge clk);
        ret_valid  = valid;
        ret_atomic = atomic;
        ret_addr   = ADDR_W'(addr);
        ret_old    = DATA_W'(old_v);
        ret_new    = DATA_W'(new_v);
        if (valid) begin
            if (!atomic) begin
                if (m_open) m_t++;
            end else if (old_v == new_v) begin
                if (m_open && m_addr == addr) m_t++;
                else begin m_open = 1; m_addr = addr; m_t = 0; end
            end else begin
                if (m_open && m_addr == addr) begin
                    exp_item_t it;
                    it.len = (m_t + 1 > TMAXI) ? TMAXI : m_t + 1;
                    it.wt  = (it.len > LIMIT);
                    it.tag = tag;
                    exp_q.push_back(it);
                    if (it.wt) m_wait = sat_add(m_wait, 1);
                    else begin
                        m_spin = sat_add(m_spin, 1);
                        m_sins = sat_add(m_sins, it.len);
                    end
                    m_open = 0;
                end else begin
                    m_unc = sat_add(m_unc, 1);
                    if (m_open) m_t++;
                end
            end
        end
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) retire(0, 0, 0, 0, 0, "");
    endtask
    task automatic plain(int n);
        for (int i = 0; i < n; i++) retire(1, 0, 0, 5, 5, "");
    endtask
    task automatic fail_on(int a);
        retire(1, 1, a, 8'hff, 8'hff, "");
    endtask
    task automatic grab(int a, string tag);
        retire(1, 1, a, 0, 8'hff, tag);
    endtask

    task automatic check_counters(string tag);
        idle(1);
        check({tag, " spin_eps R5"},    int'(spin_eps),    m_spin);
        check({tag, " wait_eps R5"},    int'(wait_eps),    m_wait);
        check({tag, " spin_instrs R6"}, int'(spin_instrs), m_sins);
        check({tag, " uncont R2"},      int'(uncont_acqs), m_unc);
    endtask

    // Monitor: pop and compare each report
    always @(negedge clk) begin
        if (!rst && ep_done) begin
            if (exp_q.size() == 0) begin
                checks++; fails++;
                $display("FAIL R2 unexpected ep_done actual=1 expected=0 len=%0d", ep_len);
            end else begin
                exp_item_t it;
                it = exp_q.pop_front();
                check({it.tag, " ep_len R3"}, int'(ep_len), it.len);
                check({it.tag, " ep_wait R4"}, int'(ep_wait), int'(it.wt));
            end
        end
    end

    // Watchdog
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done_flag) begin
            done_flag = 1;
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected<=100000", cyc);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 ep_done", int'(ep_done), 0);
        check("R1 spin_eps", int'(spin_eps), 0);
        check("R1 wait_eps", int'(wait_eps), 0);
        check("R1 spin_instrs", int'(spin_instrs), 0);
        check("R1 uncont", int'(uncont_acqs), 0);
        rst = 1'b0;

        // R2: uncontended acquisition, no report; non-atomic equal values ignored
        plain(2);
        grab(3, "R2");
        check_counters("R2");

        // R3: fail then immediate grab gives length 1
        fail_on(4);
        grab(4, "R3 len1");
        // R9: idle cycles not counted, plain instructions counted
        fail_on(4);
        plain(2); idle(3); plain(2);
        grab(4, "R9 len5");
        check_counters("R3/R9");

        // R4: boundary at the cutoff
        fail_on(7); plain(LIMIT - 1); grab(7, "R4 at-limit");
        fail_on(7); plain(LIMIT);     grab(7, "R4 over-limit");
        check_counters("R4");

        // R7: restart on another address
        fail_on(1); plain(3); fail_on(2); plain(2);
        grab(2, "R7 restart");
        grab(1, "R7 old-addr");
        check_counters("R7");

        // R8: repeated failure on same address
        fail_on(9); fail_on(9); fail_on(9); fail_on(9);
        grab(9, "R8 retry");

        // R12: grab of other address inside an episode
        fail_on(10); grab(11, "R12 other"); plain(1);
        grab(10, "R12 len3");
        check_counters("R8/R12");

        // R10: timer saturation
        fail_on(12); plain(TMAXI + 8);
        grab(12, "R10 sat");
        check_counters("R10");

        // R11: counter saturation
        for (int i = 0; i < CMAXI + 5; i++) begin
            fail_on(20); plain(1); grab(20, "R11 loop");
        end
        check_counters("R11");
        check("R11 spin_eps pinned", int'(spin_eps), CMAXI);
        check("R11 spin_instrs pinned", int'(spin_instrs), CMAXI);

        idle(3);
        check("R3 no pending reports", exp_q.size(), 0);
        if (!done_flag) begin
            done_flag = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule